// File: doc/BRIEF.md
# Multi-function GPIO pad bank

This block manages a bank of general-purpose pads, 27 by default, behind a small synchronous register port. Software sets five per-pin registers: output data, direction, pullup enable, pulldown enable and control select. The block turns these into pad-side output enable, output value and pull controls. Raw pad levels pass through a synchronizer and can always be read back, whatever each pin's direction.

The control-select bit turns a pin from a plain data bit into a dedicated function. The function depends on where the pin sits in the bank.
- Some pins become sleep-gated outputs, which drop low while the sleep-off input is low.
- Three pins carry the low bits of an index value. All three are forced high when that index leaves a configured window.
- Two pins become inputs that are mixed into a speaker signal.
- The remaining pins with a function pass through a dedicated internal control signal.
- Pins with no control function ignore the select bit.

Pin roles and the index window are parameters.

Top module: `gpio_bank`

## Requirements
- R1: The register file is written on a rising clock edge when `wr_en` is high. The target is chosen by `addr`: 0 output data, 1 direction, 2 pullup enable, 3 pulldown enable, 4 control select. `rdata` is registered. After each edge it holds the register selected by `addr` as it stood before that edge. Addresses 5 to 7 read zero.
- R2: Reset is asynchronous and active low. It clears output data, direction, pullup and control select, and sets every pulldown bit. Right after reset, `pad_oe` is all zeros, `pad_pd` is all ones and `pad_pu` is all zeros.
- R3: A read at address 0 returns pad levels, not the output data register, whatever the direction. The level seen in `rdata` after edge n is `pad_in` as sampled at edge n-2.
- R4: `pad_pd` equals the pulldown register. `pad_pu` is the pullup register with every bit cleared where the pulldown is set, so the two are never high together on one pin.
- R5: `pad_oe` follows the direction register. The exception is the speaker-input pins (bits 12 and 13), whose enable is forced to 0 while their control-select bit is set.
- R6: A pin drives its output data bit in two cases: its control-select bit is clear, or it is one of the pins with no control function (bits 24 to 26).
- R7: A sleep-gated pin (bits 3 to 7 and 14 to 15) with its control-select bit set drives its data bit ANDed with `sleep_n`.
- R8: An index pin (bits 0 to 2) with its select bit set drives `idx_val` bit p. If `idx_val` is below 8'h60 or above 8'h6F, all three index pins drive 1 instead.
- R9: A dedicated-function pin (bits 8 to 11 and 16 to 23) with its select bit set drives `ctrl_src` at its own bit position.
- R10: `spk_out` is `spk_in` XOR the synchronized level of each speaker-input pin whose control-select bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | 27 | Write data, one bit per pin |
| rdata | output | 27 | Registered read data |
| pad_in | input | 27 | Raw pad levels |
| pad_oe | output | 27 | Pad output enables |
| pad_out | output | 27 | Pad output values |
| pad_pu | output | 27 | Pullup enables |
| pad_pd | output | 27 | Pulldown enables |
| sleep_n | input | 1 | Sleep-off signal, low in deep sleep |
| idx_val | input | 8 | Index value for index pins |
| ctrl_src | input | 27 | Dedicated control signals, one per pin position |
| spk_in | input | 1 | Internal speaker signal |
| spk_out | output | 1 | Speaker signal after mixing |

## Verification
The configuration registers feed the pad outputs directly through logic, with no output register. So a corrupted data, direction, pull or select bit shows on the pad pins in the cycle after the write that should have set it. It shows again in `rdata` one cycle after that register is addressed. A fault in the synchronizer depth or in the address-0 readback path shows as pad levels that arrive a cycle early or late, or as data register contents where levels were expected. The bench's reference model catches that on the first mismatching read. Faults in the pin-role selection show only while a pin's select bit is set, under the matching sleep, index-window or control-source condition. The stimulus therefore drives each of those conditions, including both edges of the index window.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
   // Role a pin takes when its control-select bit is set.
   typedef enum logic [2:0] {
      PK_PLAIN = 3'd0,
      PK_SLEEP = 3'd1,
      PK_INDEX = 3'd2,
      PK_SPKIN = 3'd3,
      PK_DEDIC = 3'd4
   } pin_kind_e;

   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] A_DATA = 3'd0;
   localparam logic [REG_AW-1:0] A_DIR  = 3'd1;
   localparam logic [REG_AW-1:0] A_PU   = 3'd2;
   localparam logic [REG_AW-1:0] A_PD   = 3'd3;
   localparam logic [REG_AW-1:0] A_CSEL = 3'd4;
endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
   parameter int W      = 27,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_err_depth
      $error("gpio_bank_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NPINS = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [NPINS-1:0]  wdata,
   input  logic [NPINS-1:0]  level,
   output logic [NPINS-1:0]  rdata,
   output logic [NPINS-1:0]  data_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  pu_q,
   output logic [NPINS-1:0]  pd_q,
   output logic [NPINS-1:0]  csel_q
);
   logic [NPINS-1:0] rd_mux;

   always_comb begin
      unique case (addr)
         A_DATA:  rd_mux = level;
         A_DIR:   rd_mux = dir_q;
         A_PU:    rd_mux = pu_q;
         A_PD:    rd_mux = pd_q;
         A_CSEL:  rd_mux = csel_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         pu_q   <= '0;
         pd_q   <= '1;
         csel_q <= '0;
         rdata  <= '0;
      end else begin
         rdata <= rd_mux;
         if (wr_en) begin
            case (addr)
               A_DATA:  data_q <= wdata;
               A_DIR:   dir_q  <= wdata;
               A_PU:    pu_q   <= wdata;
               A_PD:    pd_q   <= wdata;
               A_CSEL:  csel_q <= wdata;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_bank_pin.sv
`timescale 1ns/1ps
module gpio_bank_pin
   import gpio_bank_pkg::*;
#(
   parameter pin_kind_e KIND = PK_PLAIN
) (
   input  logic data,
   input  logic dir,
   input  logic csel,
   input  logic sleep_n,
   input  logic idx_bit,
   input  logic ctrl_bit,
   output logic oe,
   output logic out
);
   always_comb begin
      oe  = dir;
      out = data;
      case (KIND)
         PK_SLEEP: if (csel) out = data & sleep_n;
         PK_INDEX: if (csel) out = idx_bit;
         PK_DEDIC: if (csel) out = ctrl_bit;
         PK_SPKIN: if (csel) oe  = 1'b0;
         default:  ;
      endcase
   end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int               NPINS       = 27,
   parameter int               IDX_W       = 8,
   parameter int               IDX_LO      = 'h60,
   parameter int               IDX_HI      = 'h6F,
   parameter int               SYNC_STAGES = 2,
   parameter logic [NPINS-1:0] SLEEP_MASK  = 27'h000C0F8,
   parameter logic [NPINS-1:0] INDEX_MASK  = 27'h0000007,
   parameter logic [NPINS-1:0] SPKIN_MASK  = 27'h0003000,
   parameter logic [NPINS-1:0] DEDIC_MASK  = 27'h0FF0F00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [NPINS-1:0]  wdata,
   output logic [NPINS-1:0]  rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_pu,
   output logic [NPINS-1:0]  pad_pd,
   input  logic              sleep_n,
   input  logic [IDX_W-1:0]  idx_val,
   input  logic [NPINS-1:0]  ctrl_src,
   input  logic              spk_in,
   output logic              spk_out
);
   localparam logic [IDX_W-1:0] LO_V = IDX_LO[IDX_W-1:0];
   localparam logic [IDX_W-1:0] HI_V = IDX_HI[IDX_W-1:0];

   // Elaboration-time checks on the parameter set.
   if (((SLEEP_MASK & INDEX_MASK) | (SLEEP_MASK & SPKIN_MASK) | (SLEEP_MASK & DEDIC_MASK) |
        (INDEX_MASK & SPKIN_MASK) | (INDEX_MASK & DEDIC_MASK) | (SPKIN_MASK & DEDIC_MASK)) != '0)
   begin : g_err_overlap
      $error("gpio_bank: pin role masks overlap");
   end
   if (IDX_W < NPINS && (INDEX_MASK >> IDX_W) != '0) begin : g_err_idx
      $error("gpio_bank: index pin beyond index width");
   end
   if (IDX_LO > IDX_HI || IDX_HI >= (1 << IDX_W)) begin : g_err_window
      $error("gpio_bank: bad index window");
   end

   function automatic pin_kind_e kind_of(input int p);
      if (SLEEP_MASK[p])      return PK_SLEEP;
      else if (INDEX_MASK[p]) return PK_INDEX;
      else if (SPKIN_MASK[p]) return PK_SPKIN;
      else if (DEDIC_MASK[p]) return PK_DEDIC;
      else                    return PK_PLAIN;
   endfunction

   logic [NPINS-1:0] level;
   logic [NPINS-1:0] data_q, dir_q, pu_q, pd_q, csel_q;
   logic             idx_oor;
   logic [IDX_W-1:0] idx_eff;

   gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (level)
   );

   gpio_bank_regs #(.NPINS(NPINS)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .level  (level),
      .rdata  (rdata),
      .data_q (data_q),
      .dir_q  (dir_q),
      .pu_q   (pu_q),
      .pd_q   (pd_q),
      .csel_q (csel_q)
   );

   assign idx_oor = (idx_val < LO_V) || (idx_val > HI_V);
   assign idx_eff = idx_oor ? '1 : idx_val;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      localparam pin_kind_e K = kind_of(p);
      gpio_bank_pin #(.KIND(K)) u_pin (
         .data     (data_q[p]),
         .dir      (dir_q[p]),
         .csel     (csel_q[p]),
         .sleep_n  (sleep_n),
         .idx_bit  (idx_eff[p % IDX_W]),
         .ctrl_bit (ctrl_src[p]),
         .oe       (pad_oe[p]),
         .out      (pad_out[p])
      );
   end

   // Pulldown wins over pullup.
   assign pad_pd  = pd_q;
   assign pad_pu  = pu_q & ~pd_q;
   assign spk_out = spk_in ^ (^(level & csel_q & SPKIN_MASK));
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int               NPINS      = 27,
   parameter logic [NPINS-1:0] SLEEP_MASK = 27'h000C0F8,
   parameter logic [NPINS-1:0] SPKIN_MASK = 27'h0003000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] addr,
   input logic [NPINS-1:0]  wdata,
   input logic [NPINS-1:0]  rdata,
   input logic [NPINS-1:0]  pad_in,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_pu,
   input logic [NPINS-1:0]  pad_pd,
   input logic              sleep_n,
   input logic [NPINS-1:0]  csel_q
);
   logic [2:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 3'd7) cyc <= cyc + 3'd1;
   end

   a_r3_level_read: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_DATA && cyc >= 3'd2) |=> rdata == $past(pad_in, 3));

   a_r4_pd_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PD) |=> pad_pd == $past(wdata));

   a_r4_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_pd) == '0);

   a_r5_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DIR) |=> (pad_oe & ~SPKIN_MASK) == ($past(wdata) & ~SPKIN_MASK));

   a_r5_spk_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & csel_q & SPKIN_MASK) == '0);

   a_r7_sleep_low: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |-> (pad_out & csel_q & SLEEP_MASK) == '0);
endmodule

bind gpio_bank gpio_bank_chk #(
   .NPINS      (NPINS),
   .SLEEP_MASK (SLEEP_MASK),
   .SPKIN_MASK (SPKIN_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .pad_in  (pad_in),
   .pad_oe  (pad_oe),
   .pad_out (pad_out),
   .pad_pu  (pad_pu),
   .pad_pd  (pad_pd),
   .sleep_n (sleep_n),
   .csel_q  (csel_q)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
   localparam int N = 27;
   localparam logic [N-1:0] M_SLEEP = 27'h000C0F8;
   localparam logic [N-1:0] M_INDEX = 27'h0000007;
   localparam logic [N-1:0] M_SPK   = 27'h0003000;
   localparam logic [N-1:0] M_DEDIC = 27'h0FF0F00;
   localparam int WIN_LO = 'h60;
   localparam int WIN_HI = 'h6F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [N-1:0] wdata = '0, pad_in = '0, ctrl_src = '0;
   logic sleep_n = 1'b1, spk_in = 1'b0;
   logic [7:0] idx_val = '0;
   logic [N-1:0] rdata, pad_oe, pad_out, pad_pu, pad_pd;
   logic spk_out;

   always #2.5 clk = ~clk;

   gpio_bank uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pu(pad_pu), .pad_pd(pad_pd), .sleep_n(sleep_n), .idx_val(idx_val),
      .ctrl_src(ctrl_src), .spk_in(spk_in), .spk_out(spk_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit model_live = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [N-1:0] m_data, m_dir, m_pu, m_pd, m_csel, m_rdata;
   logic [N-1:0] m_sync[$];
   logic [2:0]   m_last_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data = '0; m_dir = '0; m_pu = '0; m_pd = '1; m_csel = '0; m_rdata = '0;
         m_sync = {};
         m_sync.push_back('0);
         m_sync.push_back('0);
         m_last_addr = 3'd7;
      end else begin
         case (addr)
            3'd0: m_rdata = m_sync[0];
            3'd1: m_rdata = m_dir;
            3'd2: m_rdata = m_pu;
            3'd3: m_rdata = m_pd;
            3'd4: m_rdata = m_csel;
            default: m_rdata = '0;
         endcase
         m_last_addr = addr;
         if (wr_en) begin
            case (addr)
               3'd0: m_data = wdata;
               3'd1: m_dir = wdata;
               3'd2: m_pu = wdata;
               3'd3: m_pd = wdata;
               3'd4: m_csel = wdata;
               default: ;
            endcase
         end
         void'(m_sync.pop_front());
         m_sync.push_back(pad_in);
      end
      model_live = 1'b1;
   end

   always @(negedge clk) begin
      if (model_live && !done) begin
         bit oor;
         logic spk_exp;
         oor = (int'(idx_val) < WIN_LO) || (int'(idx_val) > WIN_HI);
         chk(m_last_addr == 3'd0 ? "R3 level readback" : "R1 register read", rdata, m_rdata);
         chk("R4 pulldown", pad_pd, m_pd);
         chk("R4 pullup", pad_pu, m_pu & ~m_pd);
         for (int p = 0; p < N; p++) begin
            logic eo, ev;
            string tg;
            eo = m_dir[p] && !(M_SPK[p] && m_csel[p]);
            ev = m_data[p];
            tg = "R6 plain output";
            if (m_csel[p]) begin
               if (M_SLEEP[p])      begin ev = m_data[p] & sleep_n; tg = "R7 sleep gated"; end
               else if (M_INDEX[p]) begin ev = oor ? 1'b1 : idx_val[p]; tg = "R8 index pin"; end
               else if (M_DEDIC[p]) begin ev = ctrl_src[p]; tg = "R9 dedicated"; end
            end
            chk("R5 output enable", pad_oe[p], eo);
            chk(tg, pad_out[p], ev);
         end
         spk_exp = spk_in ^ (^(m_sync[0] & m_csel & M_SPK));
         chk("R10 speaker mix", spk_out, spk_exp);
      end
   end

   task automatic step(input logic we, input logic [2:0] a, input logic [N-1:0] wd);
      @(posedge clk);
      #1;
      wr_en = we; addr = a; wdata = wd;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset oe", pad_oe, '0);
      chk("R2 reset pulldown", pad_pd, {N{1'b1}});
      chk("R2 reset pullup", pad_pu, '0);
      // read each register after reset
      for (int a = 0; a < 8; a++) step(1'b0, a[2:0], '0);
      // plain outputs and pull priority
      step(1'b1, 3'd0, 27'h5A5A5A5);
      step(1'b1, 3'd1, '1);
      step(1'b1, 3'd2, '1);
      step(1'b1, 3'd3, 27'h00000FF);
      step(1'b0, 3'd2, '0);
      // all pins to control function
      step(1'b1, 3'd4, '1);
      ctrl_src = 27'h2AAAAAA;
      step(1'b0, 3'd4, '0);
      sleep_n = 1'b0;
      step(1'b0, 3'd0, '0);
      sleep_n = 1'b1;
      step(1'b0, 3'd0, '0);
      // index window edges
      for (int v = WIN_LO - 2; v <= WIN_LO + 1; v++) begin idx_val = v[7:0]; step(1'b0, 3'd0, '0); end
      for (int v = WIN_HI - 1; v <= WIN_HI + 2; v++) begin idx_val = v[7:0]; step(1'b0, 3'd0, '0); end
      idx_val = 8'hFF; step(1'b0, 3'd0, '0);
      idx_val = 8'h00; step(1'b0, 3'd0, '0);
      // speaker inputs with readback
      pad_in = 27'h0001000; spk_in = 1'b1;
      repeat (4) step(1'b0, 3'd0, '0);
      pad_in = 27'h0003000;
      repeat (4) step(1'b0, 3'd0, '0);
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         pad_in   = N'($urandom);
         ctrl_src = N'($urandom);
         spk_in   = 1'($urandom);
         sleep_n  = ($urandom % 4) != 0;
         idx_val  = ($urandom % 2) ? 8'(WIN_LO - 2 + $urandom % 20) : 8'($urandom);
         step(($urandom % 2) == 1, 3'($urandom), N'($urandom));
      end
      step(1'b0, 3'd0, '0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule